// File: doc/BRIEF.md
# Destructive-Readout Flux Storage Cell

This block is a cycle-accurate synchronous model of a superconducting storage loop that holds a single bit as trapped flux. The bit is never read or written by level. A one-cycle pulse on the store input traps a quantum, and a one-cycle pulse on the clear input releases it. Analog behaviour, bias levels and pulse shapes are not modelled; only the logical pulse semantics are, on an ordinary system clock.

Reading is destructive. The only way to learn the content is to clear the cell. If a quantum was held, the clear produces exactly one readout pulse in the following cycle. Clearing an empty cell is silent, and storing into a full cell is absorbed. When store and clear land in the same cycle, clear wins. The held state is also brought out as a level so that a surrounding check can observe it.

Top module: `fluxcell_dro`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `flux_held_o` is 0 and `read_pulse_o` is 0, whatever the pulse inputs do during reset.
- R2: A store pulse alone on an empty cell makes `flux_held_o` read 1 from the next cycle on, with no readout pulse.
- R3: A store pulse alone on a full cell leaves `flux_held_o` at 1 and produces no readout pulse.
- R4: A clear pulse on a full cell makes `flux_held_o` read 0 from the next cycle on, and `read_pulse_o` is 1 for exactly that next cycle.
- R5: A clear pulse on an empty cell leaves `flux_held_o` at 0 and produces no readout pulse.
- R6: Store and clear in the same cycle act as a clear: the cell reads 0 afterwards, and the readout pulse in the next cycle equals the state held before that cycle.
- R7: `read_pulse_o` is never high in two consecutive cycles.
- R8: In a cycle with neither pulse, `flux_held_o` keeps its value and `read_pulse_o` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| store_pulse_i | input | 1 | One-cycle pulse that traps a quantum |
| clear_pulse_i | input | 1 | One-cycle pulse that releases the quantum and reads it out |
| read_pulse_o | output | 1 | One-cycle readout pulse, one cycle after a clear of a full cell |
| flux_held_o | output | 1 | Current stored state, 1 when a quantum is held |

## Verification
Both results of an input pulse are due one clock edge later: the new stored state and the readout pulse are registered at the edge that samples the pulse, and nothing is combinational from input to output. The bench drives each pulse on a falling edge, lets one rising edge pass, and compares both outputs at the next falling edge against a model advanced by the same one step. The expected readout is taken from the modelled state before the step, which is what separates the simultaneous store-and-clear case from a plain store.

// File: rtl/fluxcell_pkg.sv
package fluxcell_pkg;

  // Decoded action on the storage loop for one cycle.
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_STORE = 2'd1,
    CMD_CLEAR = 2'd2
  } cell_cmd_e;

endpackage

// File: rtl/fluxcell_arbiter.sv
module fluxcell_arbiter
  import fluxcell_pkg::*;
(
  input  logic      store_i,
  input  logic      clear_i,
  output cell_cmd_e cmd_o
);

  // Clear outranks store when both pulses coincide (R6).
  always_comb begin
    if (clear_i) begin
      cmd_o = CMD_CLEAR;
    end else if (store_i) begin
      cmd_o = CMD_STORE;
    end else begin
      cmd_o = CMD_IDLE;
    end
  end

endmodule

// File: rtl/fluxcell_loop.sv
module fluxcell_loop
  import fluxcell_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cell_cmd_e cmd_i,
  output logic      held_o
);

  logic held_q;
  logic held_d;
  logic held_en;

  // Next state: only a store or clear touches the loop.
  always_comb begin
    held_en = (cmd_i != CMD_IDLE);
    held_d  = (cmd_i == CMD_STORE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end

  assign held_o = held_q;

  // R2 and R3: a store leaves the loop full.
  a_r2_store_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_STORE) |=> held_q);

  // R4, R5 and R6: any clear leaves the loop empty.
  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_CLEAR) |=> !held_q);

  // R8: without a command the loop keeps its flux.
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_IDLE) |=> $stable(held_q));

endmodule

// File: rtl/fluxcell_emitter.sv
module fluxcell_emitter
  import fluxcell_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cell_cmd_e cmd_i,
  input  logic      held_i,
  output logic      pulse_o
);

  logic pulse_q;
  logic pulse_d;

  // A pulse is launched only when a clear releases a held quantum.
  always_comb begin
    pulse_d = (cmd_i == CMD_CLEAR) && held_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  // R4: clearing a full loop reads it out one cycle later.
  a_r4_readout_due: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_i == CMD_CLEAR) && held_i) |=> pulse_q);

  // R5: clearing an empty loop is silent.
  a_r5_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_i == CMD_CLEAR) && !held_i) |=> !pulse_q);

  // R8: no readout without a clear.
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i != CMD_CLEAR) |=> !pulse_q);

endmodule

// File: rtl/fluxcell_dro.sv
module fluxcell_dro
  import fluxcell_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic store_pulse_i,
  input  logic clear_pulse_i,
  output logic read_pulse_o,
  output logic flux_held_o
);

  cell_cmd_e cmd;
  logic      held;
  logic      pulse;

  fluxcell_arbiter u_arbiter (
    .store_i (store_pulse_i),
    .clear_i (clear_pulse_i),
    .cmd_o   (cmd)
  );

  fluxcell_loop u_loop (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_i  (cmd),
    .held_o (held)
  );

  fluxcell_emitter u_emitter (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_i   (cmd),
    .held_i  (held),
    .pulse_o (pulse)
  );

  assign read_pulse_o = pulse;
  assign flux_held_o  = held;

  // R7: a readout empties the cell, so a second pulse cannot follow at once.
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    read_pulse_o |=> !read_pulse_o);

  // R3: a store into a full cell is absorbed without readout.
  a_r3_store_absorbed: assert property (@(posedge clk) disable iff (!rst_n)
    (store_pulse_i && !clear_pulse_i && flux_held_o) |=> (flux_held_o && !read_pulse_o));

  // R6: coincident pulses end empty and read out the prior state.
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (store_pulse_i && clear_pulse_i) |=> (!flux_held_o && (read_pulse_o == $past(flux_held_o))));

endmodule

// File: tb/tb_fluxcell_dro.sv
module tb_fluxcell_dro;

  logic clk;
  logic rst_n;
  logic store_pulse;
  logic clear_pulse;
  logic read_pulse;
  logic flux_held;

  int   n_checks;
  int   n_fails;
  logic exp_held;
  logic exp_pulse;
  logic last_pulse;
  bit   finished;

  fluxcell_dro dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .store_pulse_i (store_pulse),
    .clear_pulse_i (clear_pulse),
    .read_pulse_o  (read_pulse),
    .flux_held_o   (flux_held)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic string classify(input logic s, input logic c, input logic h);
    if (s && c) return "R6";
    if (c)      return h ? "R4" : "R5";
    if (s)      return h ? "R3" : "R2";
    return "R8";
  endfunction

  function automatic logic model_held(input logic s, input logic c, input logic h);
    return c ? 1'b0 : (s ? 1'b1 : h);
  endfunction

  function automatic logic model_pulse(input logic c, input logic h);
    return c & h;
  endfunction

  task automatic check_bit(input string req, input string what,
                           input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge.
  task automatic step(input logic s, input logic c);
    string req;
    logic  nh;
    logic  np;
    req = classify(s, c, exp_held);
    nh  = model_held(s, c, exp_held);
    np  = model_pulse(c, exp_held);
    store_pulse = s;
    clear_pulse = c;
    @(negedge clk);
    store_pulse = 1'b0;
    clear_pulse = 1'b0;
    exp_held  = nh;
    exp_pulse = np;
    check_bit(req, "flux_held", flux_held, exp_held);
    check_bit(req, "read_pulse", read_pulse, exp_pulse);
    // R7: never two readout pulses back to back.
    check_bit("R7", "back-to-back readout", last_pulse & read_pulse, 1'b0);
    last_pulse = read_pulse;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n       = 1'b0;
    store_pulse = 1'b1;
    clear_pulse = 1'b0;
    @(negedge clk);
    check_bit("R1", "flux_held in reset", flux_held, 1'b0);
    check_bit("R1", "read_pulse in reset", read_pulse, 1'b0);
    rst_n       = 1'b1;
    store_pulse = 1'b0;
    @(negedge clk);
    check_bit("R1", "flux_held after release", flux_held, 1'b0);
    check_bit("R1", "read_pulse after release", read_pulse, 1'b0);
    exp_held   = 1'b0;
    exp_pulse  = 1'b0;
    last_pulse = 1'b0;
  endtask

  initial begin
    finished    = 1'b0;
    n_checks    = 0;
    n_fails     = 0;
    rst_n       = 1'b0;
    store_pulse = 1'b0;
    clear_pulse = 1'b0;
    exp_held    = 1'b0;
    exp_pulse   = 1'b0;
    last_pulse  = 1'b0;
    void'($urandom(32'h1f2e3d4c));

    do_reset();

    // Directed corner cases.
    step(1'b0, 1'b1);   // R5 clear on empty
    step(1'b1, 1'b0);   // R2 store on empty
    step(1'b1, 1'b0);   // R3 store on full
    step(1'b0, 1'b0);   // R8 hold full
    step(1'b0, 1'b1);   // R4 clear full -> readout
    step(1'b0, 1'b1);   // R5 second clear silent, R7
    step(1'b1, 1'b0);   // R2
    step(1'b1, 1'b1);   // R6 coincident on full -> readout
    step(1'b1, 1'b1);   // R6 coincident on empty -> silent
    step(1'b0, 1'b0);   // R8 hold empty

    // Reset while full suppresses any readout (R1).
    step(1'b1, 1'b0);
    do_reset();

    // Constrained random pulses.
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 8);
      step(r == 0 || r == 1 || r == 2 || r == 6, r == 3 || r == 4 || r == 6);
    end

    do_reset();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule